// File: doc/BRIEF.md
# Interrupt Factor and Priority Unit

This block sits between a set of peripheral event sources and a CPU. Each event pulse from interrupt system *i* latches a factor flag. Each system also holds a 3-bit priority and an enable bit. Every cycle the block picks the pending, enabled system with the highest priority. It presents that system's level and number, and raises a request when the level is above the CPU's 4-bit interrupt mask.

A system can be sent to a DMA engine instead of the CPU. When both its DMA-request bit and its DMA-enable bit are set, an event starts a transfer and does not latch the flag. The CPU sees that system only when the engine reports completion and the completion interrupt for that system is enabled.

Software clears flags and programs the DMA bits through a simple register port. A mode bit chooses between two write styles. In the first, a write of 1 clears a flag and a write of 1 sets a DMA bit. In the second, the written value is stored directly. Flags and priorities have no reset value, so software must initialise them.

Top module: `irq_factor_unit`

## Requirements
- R1: After reset, irqReq and dmaStart are 0, and the registers at addresses 1 (DMA request), 2 (DMA enable), 3 (mode), 4 (interrupt enable) and 5 (completion enable) read 0.
- R2: With mode bit 0 (address 3, bit 0) at 0, a write to the flag register (address 0) clears each flag whose data bit is 1 and leaves unchanged each flag whose data bit is 0.
- R3: With mode bit 0 at 1, a write to the flag register stores the written value, so a written 0 clears a flag.
- R4: A flag stays set until software clears it. While it is set and enabled it keeps taking part in arbitration.
- R5: A hardware set of a flag in the same cycle as a software clear of that flag leaves the flag set.
- R6: With mode 0, a write to address 1 or 2 sets each bit whose data bit is 1 and ignores data bits that are 0. With mode 1, the written value is stored.
- R7: When bit i of both address 1 and address 2 is set, an event on system i pulses dmaStart[i] for one cycle on the next clock and does not set flag i. dmaDone[i] clears bit i of address 1. It sets flag i only if bit i of address 5 is 1.
- R8: Priorities are 3 bits wide, at address 16+i. Writes keep only data bits [2:0], and irqLevel never exceeds 7.
- R9: irqSys and irqLevel name the pending system (flag AND enable) with the highest priority. On a tie the lower-numbered system wins. With nothing pending, both outputs are 0.
- R10: irqReq is 1 only when a pending system exists and its priority is strictly greater than cpuLevel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | NUM_SYS | Peripheral event pulses, one per system |
| dmaDone | input | NUM_SYS | DMA completion pulses, one per system |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | NUM_SYS | Register write data |
| rdAddr | input | ADDR_W | Register read address |
| rdData | output | NUM_SYS | Register read data, combinational |
| cpuLevel | input | LVL_W | CPU interrupt level mask |
| irqReq | output | 1 | Interrupt request to the CPU |
| irqLevel | output | LVL_W | Level of the winning system |
| irqSys | output | SYS_W | Number of the winning system |
| dmaStart | output | NUM_SYS | DMA start pulses, one per system |

## Verification
The assertions check these properties on every cycle:
- A request never appears at or below the CPU mask.
- The reported level stays within the 3-bit range.
- A requesting system is always flagged and enabled.
- Flags fall only after a write to the flag register.
- A hardware set always lands.
- Every DMA start pulse traces back to a routed event.

Only the bench scenarios can show the following: the exact result of each write style on the flag and DMA registers, the choice of winner and tie-break across priority patterns, and the completion path that depends on the completion-enable bit.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int A_FLAG      = 0;
  localparam int A_DMAREQ    = 1;
  localparam int A_DMAEN     = 2;
  localparam int A_MODE      = 3;
  localparam int A_INTEN     = 4;
  localparam int A_DONEEN    = 5;
  localparam int A_PRIO_BASE = 16;

  typedef struct packed {
    logic       wrFlag;
    logic       wrDmaReq;
    logic       wrDmaEn;
    logic       wrIntEn;
    logic       wrDoneEn;
    logic       wrPrio;
    logic [7:0] prioIdx;
    logic       rwMode;
  } strobes_t;
endpackage

// File: rtl/ifu_ctrl.sv
module ifu_ctrl #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrBit0,
  output ifu_pkg::strobes_t strb
);
  import ifu_pkg::*;

  logic modeQ;

  // Mode register: 0 = clear/set-only style, 1 = store-value style
  always_ff @(posedge clk) begin
    if (!rstN)                                 modeQ <= 1'b0;
    else if (wrEn && int'(wrAddr) == A_MODE)   modeQ <= wrBit0;
  end

  always_comb begin
    strb          = '0;
    strb.rwMode   = modeQ;
    strb.wrFlag   = wrEn && int'(wrAddr) == A_FLAG;
    strb.wrDmaReq = wrEn && int'(wrAddr) == A_DMAREQ;
    strb.wrDmaEn  = wrEn && int'(wrAddr) == A_DMAEN;
    strb.wrIntEn  = wrEn && int'(wrAddr) == A_INTEN;
    strb.wrDoneEn = wrEn && int'(wrAddr) == A_DONEEN;
    strb.wrPrio   = wrEn && int'(wrAddr) >= A_PRIO_BASE;
    strb.prioIdx  = 8'(int'(wrAddr) - A_PRIO_BASE);
  end
endmodule

// File: rtl/ifu_datapath.sv
module ifu_datapath #(
  parameter int NUM_SYS = 8,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ifu_pkg::strobes_t strb,
  input  logic [NUM_SYS-1:0] wrData,
  input  logic [NUM_SYS-1:0] evtPulse,
  input  logic [NUM_SYS-1:0] dmaDone,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [NUM_SYS-1:0] rdData,
  output logic [NUM_SYS-1:0] flagQ,
  output logic [NUM_SYS-1:0] intEnQ,
  output logic [NUM_SYS-1:0] routeMask,
  output logic [PRIO_W-1:0]  prioQ [NUM_SYS],
  output logic [NUM_SYS-1:0] dmaStartQ
);
  import ifu_pkg::*;

  logic [NUM_SYS-1:0] dmaReqQ, dmaEnQ, doneEnQ;
  logic [NUM_SYS-1:0] flagSw, hwSet, dmaReqSw, dmaEnSw;

  assign routeMask = dmaReqQ & dmaEnQ;

  // Software view of each register, then hardware events on top
  always_comb begin
    flagSw = flagQ;
    if (strb.wrFlag) flagSw = strb.rwMode ? wrData : (flagQ & ~wrData);
    dmaReqSw = dmaReqQ;
    if (strb.wrDmaReq) dmaReqSw = strb.rwMode ? wrData : (dmaReqQ | wrData);
    dmaEnSw = dmaEnQ;
    if (strb.wrDmaEn) dmaEnSw = strb.rwMode ? wrData : (dmaEnQ | wrData);
    hwSet = (evtPulse & ~routeMask) | (dmaDone & doneEnQ);
  end

  // Flags carry no reset value
  always_ff @(posedge clk) flagQ <= flagSw | hwSet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaReqQ   <= '0;
      dmaEnQ    <= '0;
      intEnQ    <= '0;
      doneEnQ   <= '0;
      dmaStartQ <= '0;
    end else begin
      dmaReqQ   <= dmaReqSw & ~dmaDone;
      dmaEnQ    <= dmaEnSw;
      dmaStartQ <= evtPulse & routeMask;
      if (strb.wrIntEn)  intEnQ  <= wrData;
      if (strb.wrDoneEn) doneEnQ <= wrData;
    end
  end

  generate
    for (genvar s = 0; s < NUM_SYS; s++) begin : g_prio
      always_ff @(posedge clk) begin
        if (strb.wrPrio && strb.prioIdx == 8'(s)) prioQ[s] <= wrData[PRIO_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    rdData = '0;
    case (int'(rdAddr))
      A_FLAG:   rdData = flagQ;
      A_DMAREQ: rdData = dmaReqQ;
      A_DMAEN:  rdData = dmaEnQ;
      A_MODE:   rdData = NUM_SYS'(strb.rwMode);
      A_INTEN:  rdData = intEnQ;
      A_DONEEN: rdData = doneEnQ;
      default: begin
        for (int s = 0; s < NUM_SYS; s++)
          if (int'(rdAddr) == A_PRIO_BASE + s) rdData = NUM_SYS'(prioQ[s]);
      end
    endcase
  end
endmodule

// File: rtl/ifu_arbiter.sv
module ifu_arbiter #(
  parameter int NUM_SYS = 8,
  parameter int PRIO_W  = 3,
  parameter int LVL_W   = 4,
  localparam int SYS_W  = $clog2(NUM_SYS)
) (
  input  logic [NUM_SYS-1:0] pend,
  input  logic [PRIO_W-1:0]  prio [NUM_SYS],
  input  logic [LVL_W-1:0]   cpuLevel,
  output logic               irqReq,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [SYS_W-1:0]   irqSys
);
  logic              found;
  logic [PRIO_W-1:0] best;

  // Scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    found  = 1'b0;
    best   = '0;
    irqSys = '0;
    for (int i = NUM_SYS - 1; i >= 0; i--) begin
      if (pend[i] && (!found || prio[i] >= best)) begin
        found  = 1'b1;
        best   = prio[i];
        irqSys = SYS_W'(i);
      end
    end
    irqLevel = found ? LVL_W'(best) : '0;
    irqReq   = found && (LVL_W'(best) > cpuLevel);
  end
endmodule

// File: rtl/irq_factor_unit.sv
module irq_factor_unit #(
  parameter int NUM_SYS = 8,
  parameter int PRIO_W  = 3,
  parameter int LVL_W   = 4,
  parameter int ADDR_W  = 5,
  localparam int SYS_W  = $clog2(NUM_SYS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SYS-1:0] evtPulse,
  input  logic [NUM_SYS-1:0] dmaDone,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [NUM_SYS-1:0] wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [NUM_SYS-1:0] rdData,
  input  logic [LVL_W-1:0]   cpuLevel,
  output logic               irqReq,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [SYS_W-1:0]   irqSys,
  output logic [NUM_SYS-1:0] dmaStart
);
  ifu_pkg::strobes_t  strb;
  logic [NUM_SYS-1:0] flagQ, intEnQ, routeMask;
  logic [PRIO_W-1:0]  prioQ [NUM_SYS];

  ifu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrBit0(wrData[0]), .strb(strb)
  );

  ifu_datapath #(.NUM_SYS(NUM_SYS), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .evtPulse(evtPulse), .dmaDone(dmaDone), .rdAddr(rdAddr), .rdData(rdData),
    .flagQ(flagQ), .intEnQ(intEnQ), .routeMask(routeMask), .prioQ(prioQ),
    .dmaStartQ(dmaStart)
  );

  ifu_arbiter #(.NUM_SYS(NUM_SYS), .PRIO_W(PRIO_W), .LVL_W(LVL_W)) u_arb (
    .pend(flagQ & intEnQ), .prio(prioQ), .cpuLevel(cpuLevel),
    .irqReq(irqReq), .irqLevel(irqLevel), .irqSys(irqSys)
  );
endmodule

// File: rtl/ifu_checker.sv
module ifu_checker #(
  parameter int NUM_SYS = 8,
  parameter int LVL_W   = 4,
  parameter int ADDR_W  = 5,
  localparam int SYS_W  = $clog2(NUM_SYS)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SYS-1:0] evtPulse,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [LVL_W-1:0]   cpuLevel,
  input logic               irqReq,
  input logic [LVL_W-1:0]   irqLevel,
  input logic [SYS_W-1:0]   irqSys,
  input logic [NUM_SYS-1:0] dmaStart,
  input logic [NUM_SYS-1:0] flagQ,
  input logic [NUM_SYS-1:0] intEnQ,
  input logic [NUM_SYS-1:0] routeMask
);
  logic flagWr;
  assign flagWr = wrEn && int'(wrAddr) == ifu_pkg::A_FLAG;

  p_req_above_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> irqLevel > cpuLevel);

  p_level_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqLevel <= LVL_W'(7));

  p_req_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (flagQ[irqSys] && intEnQ[irqSys]));

  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !flagWr |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    |(evtPulse & ~routeMask) |=> ((flagQ & $past(evtPulse & ~routeMask)) == $past(evtPulse & ~routeMask)));

  p_dma_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    |dmaStart |-> (dmaStart == $past(evtPulse & routeMask)));
endmodule

bind irq_factor_unit ifu_checker #(.NUM_SYS(NUM_SYS), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn), .wrAddr(wrAddr),
  .cpuLevel(cpuLevel), .irqReq(irqReq), .irqLevel(irqLevel), .irqSys(irqSys),
  .dmaStart(dmaStart), .flagQ(flagQ), .intEnQ(intEnQ), .routeMask(routeMask)
);

// File: tb/test_irq_factor_unit.sv
module test_irq_factor_unit;
  localparam int NS = 8;
  logic clk = 1'b0, rstN = 1'b0;
  logic [NS-1:0] evtPulse = '0, dmaDone = '0, wrData = '0, rdData, dmaStart;
  logic wrEn = 1'b0, irqReq;
  logic [4:0] wrAddr = '0, rdAddr = '0;
  logic [3:0] cpuLevel = '0, irqLevel;
  logic [2:0] irqSys;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  irq_factor_unit i_irq_factor_unit (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .dmaDone(dmaDone),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .cpuLevel(cpuLevel), .irqReq(irqReq), .irqLevel(irqLevel), .irqSys(irqSys),
    .dmaStart(dmaStart)
  );

  typedef struct packed {
    logic [23:0] prio;   // octal digit i = priority of system i
    logic [7:0]  flags;
    logic [3:0]  cpu;
    logic        req;
    logic [3:0]  lvl;
    logic [2:0]  sys;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{24'o76543210, 8'hFF, 4'd0,  1'b1, 4'd7, 3'd7},
    '{24'o76543210, 8'h0F, 4'd0,  1'b1, 4'd3, 3'd3},
    '{24'o76543210, 8'h0F, 4'd3,  1'b0, 4'd3, 3'd3},
    '{24'o55555555, 8'h30, 4'd4,  1'b1, 4'd5, 3'd4},
    '{24'o55555555, 8'h00, 4'd0,  1'b0, 4'd0, 3'd0},
    '{24'o26222222, 8'h41, 4'd15, 1'b0, 4'd6, 3'd6},
    '{24'o26222222, 8'h41, 4'd5,  1'b1, 4'd6, 3'd6},
    '{24'o26222222, 8'h41, 4'd6,  1'b0, 4'd6, 3'd6}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [NS-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int a, output logic [NS-1:0] d);
    rdAddr = 5'(a);
    #0.5;
    d = rdData;
  endtask

  task automatic pulse(logic [NS-1:0] e, logic [NS-1:0] dn);
    @(negedge clk);
    evtPulse = e; dmaDone = dn;
    @(negedge clk);
    evtPulse = '0; dmaDone = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NS-1:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irqReq", 32'(irqReq), 0);
    chk("R1 dmaStart", 32'(dmaStart), 0);
    for (int a = 1; a <= 5; a++) begin rd(a, d); chk("R1 reg", 32'(d), 0); end

    // Initialise undefined state
    wr(3, 8'h01); wr(0, 8'h00);
    for (int s = 0; s < NS; s++) wr(16 + s, 8'h00);

    // R9 R10 table
    wr(4, 8'hFF);
    foreach (VECS[v]) begin
      for (int s = 0; s < NS; s++) wr(16 + s, 8'(VECS[v].prio[3*s +: 3]));
      wr(0, VECS[v].flags);
      cpuLevel = VECS[v].cpu;
      #0.5;
      chk("R10 irqReq", 32'(irqReq), 32'(VECS[v].req));
      chk("R9 irqLevel", 32'(irqLevel), 32'(VECS[v].lvl));
      chk("R9 irqSys", 32'(irqSys), 32'(VECS[v].sys));
    end
    // R9 enable gating: system 6 disabled, system 0 (prio 2) wins
    wr(4, 8'hBF); cpuLevel = 4'd0; #0.5;
    chk("R9 enable gate sys", 32'(irqSys), 0);
    chk("R9 enable gate lvl", 32'(irqLevel), 2);
    wr(4, 8'hFF);

    // R8 priority width
    wr(16, 8'hFF); rd(16, d); chk("R8 prio bits", 32'(d), 7);

    // R2 clear-by-one mode
    wr(0, 8'h00); wr(3, 8'h00);
    pulse(8'hFF, 8'h00);
    rd(0, d); chk("R2 events set", 32'(d), 32'hFF);
    wr(0, 8'h0F); rd(0, d); chk("R2 clear ones", 32'(d), 32'hF0);
    wr(0, 8'h00); rd(0, d); chk("R2 zero ignored", 32'(d), 32'hF0);

    // R3 store mode
    wr(3, 8'h01); wr(0, 8'h0C); rd(0, d); chk("R3 store", 32'(d), 32'h0C);

    // R4 flag held, still requesting
    for (int s = 0; s < NS; s++) wr(16 + s, 8'h03);
    cpuLevel = 4'd1;
    repeat (5) @(negedge clk);
    rd(0, d); chk("R4 hold", 32'(d), 32'h0C);
    chk("R4 request", 32'(irqReq), 1);
    chk("R4 sys", 32'(irqSys), 2);

    // R5 set wins over clear
    wr(3, 8'h00);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd0; wrData = 8'h0C; evtPulse = 8'h04;
    @(negedge clk);
    wrEn = 1'b0; evtPulse = '0;
    rd(0, d); chk("R5 set wins", 32'(d), 32'h04);

    // R6 DMA registers
    wr(2, 8'h03); wr(2, 8'h04); rd(2, d); chk("R6 set-only", 32'(d), 32'h07);
    wr(2, 8'h00); rd(2, d); chk("R6 zero ignored", 32'(d), 32'h07);
    wr(3, 8'h01); wr(2, 8'h01); rd(2, d); chk("R6 store", 32'(d), 32'h01);
    wr(1, 8'h02); rd(1, d); chk("R6 req store", 32'(d), 32'h02);

    // R7 routing to DMA
    wr(0, 8'h00); wr(1, 8'h01); wr(5, 8'h00);
    @(negedge clk); evtPulse = 8'h01;
    @(negedge clk); evtPulse = '0;
    chk("R7 start pulse", 32'(dmaStart), 32'h01);
    rd(0, d); chk("R7 flag not set", 32'(d), 0);
    @(negedge clk);
    chk("R7 pulse ends", 32'(dmaStart), 0);
    pulse(8'h00, 8'h01);
    rd(1, d); chk("R7 done clears req", 32'(d), 0);
    rd(0, d); chk("R7 no done irq", 32'(d), 0);
    wr(1, 8'h01); wr(5, 8'h01);
    pulse(8'h01, 8'h00);
    pulse(8'h00, 8'h01);
    rd(0, d); chk("R7 done irq", 32'(d), 32'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule